// File: doc/BRIEF.md
# Transmit Event Log Queue

This block keeps a log of served transmit requests. A transmit scheduler outside the block pulses a serve strobe each time it finishes with a transmit buffer. With the strobe it presents the buffer's message identifier, its data length code, the buffer's own log-enable bit, a cancel flag and a flag that says whether the transmission ran with automatic retransmission switched off. When the log-enable bit is set and the request was not cancelled, the block builds an entry. The entry holds the identifier, the length code, a 16-bit timestamp and an event kind, and goes into a 32-deep first-in first-out store. The host drains the store in batches, in service order, and does this independently of the transmissions.

Entries leave through a valid/ready stream. `ev_valid` is high whenever the store holds at least one entry, and the entry fields always show the oldest one. An entry is removed on a clock edge where `ev_valid` and `ev_ready` are both high. While the host holds `ev_ready` low, the head entry and `ev_valid` stay unchanged. The write side has no back-pressure. An event that finds the store full is discarded and raises a sticky overflow flag.

The block also reports the current fill level and full and empty status. It drives a level-type watermark interrupt that the host can enable.

Top module: `txev_log`

## Requirements
- R1: After reset the store is empty: `fifo_empty`=1, `fifo_full`=0, `fill_level`=0, `ev_valid`=0, `ovf_flag`=0, `wm_irq`=0.
- R2: A strobe on `srv_valid` creates an entry only when `srv_log_en`=1 and `srv_cancel`=0. Every other strobe leaves the store unchanged.
- R3: An entry carries `srv_id` and `srv_dlc` unchanged. Its event kind `ev_kind` is 2'b01 for a normal transmission and 2'b10 when `srv_noretx`=1.
- R4: The timestamp is a 16-bit counter that reads 0 in the first cycle after reset is released, rises by one every cycle and wraps. An entry takes the counter value of the cycle in which its strobe is high.
- R5: Status updates only after the request has been retired. The clock edge that samples the strobe leaves `fill_level`, `fifo_empty` and `ev_valid` unchanged. The entry becomes visible after the next edge.
- R6: Entries leave in the order they were served. An entry is removed on an edge where `ev_valid` and `ev_ready` are both high. While `ev_ready` is low, the head fields stay stable.
- R7: `fill_level` equals the number of stored entries. `ev_valid` = !`fifo_empty`, and `fifo_full`=1 exactly at 32 entries.
- R8: An entry that reaches the store while it is full is discarded, even if a pop happens on the same edge, and `ovf_flag` is set. The flag holds until `ovf_clr` is sampled high. A new overflow on that same edge wins over the clear.
- R9: `wm_irq` is high exactly while `wm_irq_en`=1 and `fill_level` >= `wm_thresh`.
- R10: A write and a pop on the same edge leave `fill_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| srv_valid | input | 1 | One-cycle strobe: a transmit request was retired |
| srv_log_en | input | 1 | Log-enable bit of the served buffer |
| srv_cancel | input | 1 | Request was retired by cancellation |
| srv_noretx | input | 1 | Transmission used no automatic retransmission |
| srv_id | input | 29 | Message identifier of the served buffer |
| srv_dlc | input | 4 | Data length code of the served buffer |
| ev_valid | output | 1 | Head entry available |
| ev_ready | input | 1 | Host accepts the head entry |
| ev_id | output | 29 | Head entry identifier |
| ev_dlc | output | 4 | Head entry length code |
| ev_ts | output | 16 | Head entry timestamp |
| ev_kind | output | 2 | Head entry event kind |
| fill_level | output | 6 | Number of stored entries |
| fifo_full | output | 1 | Store holds 32 entries |
| fifo_empty | output | 1 | Store holds no entry |
| wm_thresh | input | 6 | Watermark threshold |
| wm_irq_en | input | 1 | Watermark interrupt enable |
| wm_irq | output | 1 | Watermark interrupt (level) |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
A corrupt read or write pointer shows up at the stream port the next time the host drains the store. Identifiers then come back out of order, repeated or skipped, and a drain of a known batch exposes this within one entry. A wrong occupancy count shows up one cycle after the disturbing edge, as a `fill_level`, full or watermark mismatch against the number of entries served and drained. A staging fault is caught within two cycles of a strobe: the entry appears too early, is lost, or carries a timestamp other than the counter value of its strobe cycle.

// File: rtl/txev_pkg.sv
package txev_pkg;
  localparam int ID_W  = 29;
  localparam int DLC_W = 4;
  localparam int TS_W  = 16;

  typedef enum logic [1:0] {
    EV_NONE      = 2'b00,
    EV_TX        = 2'b01,
    EV_TX_NORETX = 2'b10
  } ev_kind_e;

  typedef struct packed {
    logic [ID_W-1:0]  id;
    logic [DLC_W-1:0] dlc;
    logic [TS_W-1:0]  ts;
    ev_kind_e         kind;
  } ev_entry_t;
endpackage

// File: rtl/txev_tstamp.sv
module txev_tstamp #(
  parameter int TS_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  output logic [TS_W-1:0] ts
);
  always_ff @(posedge clk) begin
    if (!rst_n) ts <= '0;
    else        ts <= ts + 1'b1;
  end

  AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> ts == TS_W'($past(ts) + 1'b1)); // R4
endmodule

// File: rtl/txev_capture.sv
module txev_capture
  import txev_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             srv_valid,
  input  logic             srv_log_en,
  input  logic             srv_cancel,
  input  logic             srv_noretx,
  input  logic [ID_W-1:0]  srv_id,
  input  logic [DLC_W-1:0] srv_dlc,
  input  logic [TS_W-1:0]  ts,
  output logic             wr_vld,
  output ev_entry_t        wr_entry
);
  logic take;
  assign take = srv_valid && srv_log_en && !srv_cancel;

  always_ff @(posedge clk) begin
    if (!rst_n) wr_vld <= 1'b0;
    else        wr_vld <= take;
  end

  always_ff @(posedge clk) begin
    if (take) begin
      wr_entry.id   <= srv_id;
      wr_entry.dlc  <= srv_dlc;
      wr_entry.ts   <= ts;
      wr_entry.kind <= srv_noretx ? EV_TX_NORETX : EV_TX;
    end
  end

  AST_CANCEL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (srv_valid && srv_cancel) |=> !wr_vld); // R2
endmodule

// File: rtl/txev_fifo.sv
module txev_fifo
  import txev_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  ev_entry_t        push_entry,
  output logic             rd_valid,
  input  logic             rd_ready,
  output ev_entry_t        rd_entry,
  output logic [LVL_W-1:0] level,
  output logic             full,
  output logic             empty,
  output logic             dropped
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [AW-1:0]    LAST = AW'(DEPTH - 1);
  localparam logic [LVL_W-1:0] CAP  = LVL_W'(DEPTH);

  ev_entry_t     mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          do_push, do_pop;

  assign full     = (level == CAP);
  assign empty    = (level == '0);
  assign rd_valid = !empty;
  assign rd_entry = mem[rd_ptr];
  assign do_pop   = rd_valid && rd_ready;
  assign do_push  = push && !full;
  assign dropped  = push && full;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_entry;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (do_push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CAP); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full) |=> level <= $past(level)); // R8
  AST_STABLE_HEAD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> rd_valid && $stable(rd_entry)); // R6
  AST_PUSH_POP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && rd_valid && rd_ready) |=> $stable(level)); // R10
endmodule

// File: rtl/txev_status.sv
module txev_status #(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             dropped,
  input  logic             ovf_clr,
  input  logic [LVL_W-1:0] level,
  input  logic [LVL_W-1:0] wm_thresh,
  input  logic             wm_irq_en,
  output logic             wm_irq,
  output logic             ovf_flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)       ovf_flag <= 1'b0;
    else if (dropped) ovf_flag <= 1'b1;
    else if (ovf_clr) ovf_flag <= 1'b0;
  end

  assign wm_irq = wm_irq_en && (level >= wm_thresh);

  AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    dropped |=> ovf_flag); // R8
endmodule

// File: rtl/txev_log.sv
module txev_log
  import txev_pkg::*;
#(
  parameter int DEPTH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         srv_valid,
  input  logic                         srv_log_en,
  input  logic                         srv_cancel,
  input  logic                         srv_noretx,
  input  logic [28:0]                  srv_id,
  input  logic [3:0]                   srv_dlc,
  output logic                         ev_valid,
  input  logic                         ev_ready,
  output logic [28:0]                  ev_id,
  output logic [3:0]                   ev_dlc,
  output logic [15:0]                  ev_ts,
  output logic [1:0]                   ev_kind,
  output logic [$clog2(DEPTH+1)-1:0]   fill_level,
  output logic                         fifo_full,
  output logic                         fifo_empty,
  input  logic [$clog2(DEPTH+1)-1:0]   wm_thresh,
  input  logic                         wm_irq_en,
  output logic                         wm_irq,
  output logic                         ovf_flag,
  input  logic                         ovf_clr
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  logic [TS_W-1:0] ts_now;
  logic            cap_vld;
  ev_entry_t       cap_entry;
  ev_entry_t       head;
  logic            dropped;

  txev_tstamp #(.TS_W(TS_W)) u_ts (
    .clk(clk), .rst_n(rst_n), .ts(ts_now)
  );

  txev_capture u_cap (
    .clk(clk), .rst_n(rst_n),
    .srv_valid(srv_valid), .srv_log_en(srv_log_en),
    .srv_cancel(srv_cancel), .srv_noretx(srv_noretx),
    .srv_id(srv_id), .srv_dlc(srv_dlc), .ts(ts_now),
    .wr_vld(cap_vld), .wr_entry(cap_entry)
  );

  txev_fifo #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push(cap_vld), .push_entry(cap_entry),
    .rd_valid(ev_valid), .rd_ready(ev_ready), .rd_entry(head),
    .level(fill_level), .full(fifo_full), .empty(fifo_empty),
    .dropped(dropped)
  );

  txev_status #(.LVL_W(LVL_W)) u_stat (
    .clk(clk), .rst_n(rst_n), .dropped(dropped), .ovf_clr(ovf_clr),
    .level(fill_level), .wm_thresh(wm_thresh), .wm_irq_en(wm_irq_en),
    .wm_irq(wm_irq), .ovf_flag(ovf_flag)
  );

  assign ev_id   = head.id;
  assign ev_dlc  = head.dlc;
  assign ev_ts   = head.ts;
  assign ev_kind = head.kind;

  AST_NO_EARLY_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (srv_valid && !cap_vld && !(ev_valid && ev_ready)) |=> $stable(fill_level)); // R5
  AST_VALID_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid == (fill_level != '0)); // R7
endmodule

// File: tb/txev_log_test.sv
module txev_log_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {expect_entry, log_en, cancel, noretx, dlc[3:0], id[28:0]}
  localparam logic [36:0] VEC [NV] = '{
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd8,  29'h0000_0123},
    {1'b0, 1'b0, 1'b0, 1'b0, 4'd2,  29'h0000_0456},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd0,  29'h1FFF_FFFF},
    {1'b0, 1'b1, 1'b1, 1'b0, 4'd5,  29'h0ABC_0001},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd15, 29'h0000_0000},
    {1'b0, 1'b0, 1'b1, 1'b1, 4'd3,  29'h0123_4567},
    {1'b1, 1'b1, 1'b0, 1'b1, 4'd1,  29'h1555_5555},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd7,  29'h0AAA_AAAA},
    {1'b0, 1'b1, 1'b1, 1'b1, 4'd9,  29'h0000_7FF0},
    {1'b1, 1'b1, 1'b0, 1'b0, 4'd12, 29'h0000_07FF}
  };

  logic        clk = 0, rst_n = 0;
  logic        srv_valid = 0, srv_log_en = 0, srv_cancel = 0, srv_noretx = 0;
  logic [28:0] srv_id = '0;
  logic [3:0]  srv_dlc = '0;
  logic        ev_valid, ev_ready = 0;
  logic [28:0] ev_id;
  logic [3:0]  ev_dlc;
  logic [15:0] ev_ts;
  logic [1:0]  ev_kind;
  logic [5:0]  fill_level, wm_thresh = 6'd63;
  logic        fifo_full, fifo_empty, wm_irq_en = 0, wm_irq, ovf_flag, ovf_clr = 0;

  int errors = 0, checks = 0;
  bit done = 0;
  logic [15:0] bts;
  logic [28:0] m_id [64];
  logic [3:0]  m_dlc [64];
  logic [15:0] m_ts [64];
  logic [1:0]  m_kind [64];
  int mw = 0, mr = 0;

  txev_log uut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) bts <= 16'd0;
    else        bts <= bts + 16'd1;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic serve(input logic le, cn, nr, input logic [3:0] d,
                       input logic [28:0] i, input logic ex);
    srv_valid = 1; srv_log_en = le; srv_cancel = cn; srv_noretx = nr;
    srv_dlc = d; srv_id = i;
    if (ex && (mw - mr) < 32) begin
      m_id[mw % 64] = i; m_dlc[mw % 64] = d; m_ts[mw % 64] = bts;
      m_kind[mw % 64] = nr ? 2'b10 : 2'b01;
      mw++;
    end
    @(negedge clk);
    srv_valid = 0; srv_log_en = 0; srv_cancel = 0; srv_noretx = 0;
  endtask

  task automatic drain_one();
    chk(ev_valid == 1'b1, "R6 valid", ev_valid, 1);
    chk(ev_id == m_id[mr % 64], "R6 order/R3 id", ev_id, m_id[mr % 64]);
    chk(ev_dlc == m_dlc[mr % 64], "R3 dlc", ev_dlc, m_dlc[mr % 64]);
    chk(ev_kind == m_kind[mr % 64], "R3 kind", ev_kind, m_kind[mr % 64]);
    chk(ev_ts == m_ts[mr % 64], "R4 timestamp", ev_ts, m_ts[mr % 64]);
    ev_ready = 1;
    @(negedge clk);
    ev_ready = 0;
    mr++;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk(fifo_empty && !fifo_full && !ev_valid, "R1 empty flags", {fifo_empty, fifo_full, ev_valid}, 3'b100);
    chk(fill_level == 0, "R1 level", fill_level, 0);
    chk(!ovf_flag && !wm_irq, "R1 ovf/irq", {ovf_flag, wm_irq}, 0);

    // table walk: R2 gating, R3/R4 contents
    for (int k = 0; k < NV; k++)
      serve(VEC[k][35], VEC[k][34], VEC[k][33], VEC[k][32:29], VEC[k][28:0], VEC[k][36]);
    @(negedge clk); @(negedge clk);
    chk(fill_level == 6, "R2/R7 logged count", fill_level, 6);
    while (mr < mw) drain_one();
    chk(fifo_empty && !ev_valid, "R7 empty after drain", {fifo_empty, ev_valid}, 2'b10);

    // R5 status timing
    srv_valid = 1; srv_log_en = 1; srv_id = 29'h42; srv_dlc = 4'd4;
    m_id[mw % 64] = 29'h42; m_dlc[mw % 64] = 4'd4; m_ts[mw % 64] = bts; m_kind[mw % 64] = 2'b01; mw++;
    @(negedge clk);
    srv_valid = 0; srv_log_en = 0;
    chk(fill_level == 0 && fifo_empty, "R5 no early status", fill_level, 0);
    @(negedge clk);
    chk(fill_level == 1 && ev_valid, "R5 status after next edge", fill_level, 1);

    // R10 simultaneous write and pop
    serve(1'b1, 1'b0, 1'b0, 4'd6, 29'h77, 1'b1);
    ev_ready = 1;
    @(negedge clk);
    ev_ready = 0; mr++;
    chk(fill_level == 1, "R10 level held", fill_level, 1);
    chk(ev_id == 29'h77, "R10 new head", ev_id, 29'h77);

    // R6 stall holds head
    serve(1'b1, 1'b0, 1'b1, 4'd3, 29'h99, 1'b1);
    repeat (3) @(negedge clk);
    chk(ev_id == 29'h77 && ev_valid, "R6 head stable", ev_id, 29'h77);
    while (mr < mw) drain_one();

    // R9 watermark
    wm_thresh = 6'd4; wm_irq_en = 1;
    for (int k = 0; k < 3; k++) serve(1'b1, 1'b0, 1'b0, 4'd1, 29'h100 + k, 1'b1);
    @(negedge clk);
    chk(!wm_irq, "R9 below threshold", wm_irq, 0);
    serve(1'b1, 1'b0, 1'b0, 4'd1, 29'h103, 1'b1);
    @(negedge clk);
    chk(wm_irq, "R9 at threshold", wm_irq, 1);
    wm_irq_en = 0; #1;
    chk(!wm_irq, "R9 disabled", wm_irq, 0);
    wm_irq_en = 1;

    // R7/R8 fill and overflow
    for (int k = 4; k < 32; k++) serve(1'b1, 1'b0, 1'b0, 4'd2, 29'h100 + k, 1'b1);
    @(negedge clk);
    chk(fifo_full && fill_level == 32, "R7 full at 32", fill_level, 32);
    chk(!ovf_flag, "R8 no overflow yet", ovf_flag, 0);
    serve(1'b1, 1'b0, 1'b0, 4'd9, 29'h1EE, 1'b1);
    @(negedge clk);
    chk(ovf_flag, "R8 overflow set", ovf_flag, 1);
    chk(fill_level == 32, "R8 dropped entry", fill_level, 32);
    while (mr < mw) drain_one();
    chk(fifo_empty && !wm_irq, "R9 irq clears on drain", {fifo_empty, wm_irq}, 2'b10);
    chk(ovf_flag, "R8 sticky", ovf_flag, 1);
    ovf_clr = 1;
    @(negedge clk);
    ovf_clr = 0;
    chk(!ovf_flag, "R8 cleared", ovf_flag, 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule